// File: doc/BRIEF.md
# Core Power-Gating Sequencer

This block steps a single processor core through an orderly shutdown and a staged power-up. On a power-down trigger it walks through four single-cycle steps: it stops the core clock, asserts state retention, clamps the core outputs and finally switches off both groups of header switches. The core then sits in the off state until a wake request arrives.

Wake-up is done in two stages to bound inrush current. A small group of header switches turns on first, and the large group follows only after a charge interval. A two-bit mode input picks that interval: the most aggressive mode charges for the shortest time. Once the whole supply is on, the block holds the core's asynchronous reset for two cycles. It then waits a programmable restore time and releases, in order, the output clamp, the retention control and the clock. A status output tells the rest of the system whether the core is unusable.

Top module: `pg_seq_ctrl`

## Requirements
- R1: After reset the block is in the running state: clkEn=1, enFew=1, enRest=1, clampOut=0, retainEn=0, asyncRst=0, coreIdle=0.
- R2: A pdTrigger sampled high while running starts power-down. On the first following cycle clkEn goes to 0. On the second retainEn goes to 1. On the third clampOut goes to 1. On the fourth both enFew and enRest go to 0, and that off state is held. Each step lasts exactly one cycle.
- R3: enRest is never 1 while enFew is 0, and clkEn is never 1 while clampOut or retainEn is 1.
- R4: A wakeReq sampled high in the off state starts wake-up. For exactly 4*(wakeMode+1) cycles enFew=1 and enRest=0, where wakeMode is sampled on the cycle the wake begins. Code 0 is the most aggressive mode (4 cycles) and code 3 the most conservative (16 cycles).
- R5: After the charge interval both switch groups are on for one cycle with asyncRst=0. asyncRst is then 1 for exactly two cycles, and both switch groups stay on throughout.
- R6: After asyncRst falls, clampOut and retainEn stay 1 for max(restoreCycles,1) cycles. Then clampOut goes to 0, retainEn goes to 0 one cycle later, and clkEn goes to 1 one cycle after that.
- R7: A wakeReq that arrives during the three power-down steps is remembered. The off state is still reached and lasts exactly one cycle, and the wake-up then starts on its own.
- R8: coreIdle is 1 from the first power-down step to the last restore cycle, and 0 from the cycle the clamp is released onwards.
- R9: wakeReq has no effect while running. pdTrigger has no effect during power-down or wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| pdTrigger | input | 1 | Request to power the core down |
| wakeReq | input | 1 | Request to power the core up |
| wakeMode | input | 2 | Wake-up mode; sets the charge interval |
| restoreCycles | input | RESTORE_W | Restore interval in cycles (0 acts as 1) |
| clkEn | output | 1 | Core clock enable |
| retainEn | output | 1 | Retention hold (save while 1, restore on falling edge) |
| clampOut | output | 1 | Core output isolation clamp |
| enFew | output | 1 | First-stage (small) header switch enable |
| enRest | output | 1 | Second-stage (large) header switch enable |
| asyncRst | output | 1 | Core asynchronous reset pulse |
| coreIdle | output | 1 | Core is unusable (power-down through restore) |

## Verification
The embedded assertions watch the safety invariants on every cycle: the large switches never precede the small ones, the clock never runs into a clamped or retained core, the reset fires only on a fully powered core, and the shutdown and release edges occur in the allowed order. Durations cannot be seen by a cycle-local property. These are the charge length for each mode, the two-cycle reset, the restore count and its zero case, the held wake request, and the ignored requests, so the bench scenarios measure them by counting output cycles.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

  typedef enum logic [3:0] {
    ST_ACTIVE,
    ST_PD_CLK,
    ST_PD_RET,
    ST_PD_CLAMP,
    ST_OFF,
    ST_WK_FEW,
    ST_WK_ALL,
    ST_WK_RST,
    ST_WK_RESTORE,
    ST_REL_CLAMP,
    ST_REL_RET
  } pgState_t;

  // strobes from control to the interval counter
  typedef struct packed {
    logic ldCharge;
    logic ldRst;
    logic ldRestore;
  } pgStrobe_t;

  localparam int RST_PULSE_CYCLES = 2;

endpackage

// File: rtl/pg_seq_timer.sv
module pg_seq_timer
  import pg_seq_pkg::*;
#(
  parameter int CHARGE_STEP = 4,
  parameter int RESTORE_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pgStrobe_t            strobe,
  input  logic [1:0]           wakeMode,
  input  logic [RESTORE_W-1:0] restoreCycles,
  output logic                 cntDone
);

  localparam int CHARGE_MAX = 4 * CHARGE_STEP;
  localparam int CHARGE_W   = $clog2(CHARGE_MAX + 1);
  localparam int CNT_W      = (CHARGE_W > RESTORE_W) ? CHARGE_W : RESTORE_W;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] chargeVal;
  logic [CNT_W-1:0] restoreVal;

  always_comb begin
    chargeVal = CNT_W'(CHARGE_STEP) * (CNT_W'(wakeMode) + CNT_W'(1));
  end

  always_comb begin
    restoreVal = (restoreCycles == '0) ? CNT_W'(1) : CNT_W'(restoreCycles);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.ldCharge) begin
      cntQ <= chargeVal;
    end else if (strobe.ldRst) begin
      cntQ <= CNT_W'(RST_PULSE_CYCLES);
    end else if (strobe.ldRestore) begin
      cntQ <= restoreVal;
    end else if (cntQ != '0) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign cntDone = (cntQ <= CNT_W'(1));

  // R4
  charge_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldCharge |=> (cntQ >= CNT_W'(CHARGE_STEP)) && (cntQ <= CNT_W'(CHARGE_MAX)));

  // R6
  restore_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldRestore |=> (cntQ != '0));

endmodule

// File: rtl/pg_seq_fsm.sv
module pg_seq_fsm
  import pg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdTrigger,
  input  logic      wakeReq,
  input  logic      cntDone,
  output pgStrobe_t strobe,
  output logic      clkEn,
  output logic      retainEn,
  output logic      clampOut,
  output logic      enFew,
  output logic      enRest,
  output logic      asyncRst,
  output logic      coreIdle
);

  pgState_t stateQ, stateD;
  logic     pendQ, pendD;
  logic     inPowerDown;

  assign inPowerDown = (stateQ == ST_PD_CLK) || (stateQ == ST_PD_RET) ||
                       (stateQ == ST_PD_CLAMP);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_ACTIVE:     if (pdTrigger) stateD = ST_PD_CLK;
      ST_PD_CLK:     stateD = ST_PD_RET;
      ST_PD_RET:     stateD = ST_PD_CLAMP;
      ST_PD_CLAMP:   stateD = ST_OFF;
      ST_OFF: begin
        if (wakeReq || pendQ) begin
          stateD          = ST_WK_FEW;
          strobe.ldCharge = 1'b1;
        end
      end
      ST_WK_FEW:     if (cntDone) stateD = ST_WK_ALL;
      ST_WK_ALL: begin
        stateD       = ST_WK_RST;
        strobe.ldRst = 1'b1;
      end
      ST_WK_RST: begin
        if (cntDone) begin
          stateD           = ST_WK_RESTORE;
          strobe.ldRestore = 1'b1;
        end
      end
      ST_WK_RESTORE: if (cntDone) stateD = ST_REL_CLAMP;
      ST_REL_CLAMP:  stateD = ST_REL_RET;
      ST_REL_RET:    stateD = ST_ACTIVE;
      default:       stateD = ST_ACTIVE;
    endcase
  end

  always_comb begin
    pendD = pendQ;
    if (inPowerDown && wakeReq) pendD = 1'b1;
    else if (stateQ == ST_OFF)  pendD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ACTIVE;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
    end
  end

  always_comb begin
    clkEn    = (stateQ == ST_ACTIVE);
    retainEn = !((stateQ == ST_ACTIVE) || (stateQ == ST_PD_CLK) ||
                 (stateQ == ST_REL_RET));
    clampOut = !((stateQ == ST_ACTIVE) || (stateQ == ST_PD_CLK) ||
                 (stateQ == ST_PD_RET) || (stateQ == ST_REL_CLAMP) ||
                 (stateQ == ST_REL_RET));
    enFew    = (stateQ != ST_OFF);
    enRest   = (stateQ != ST_OFF) && (stateQ != ST_WK_FEW);
    asyncRst = (stateQ == ST_WK_RST);
    coreIdle = !((stateQ == ST_ACTIVE) || (stateQ == ST_REL_CLAMP) ||
                 (stateQ == ST_REL_RET));
  end

  // R3
  rest_needs_few_chk: assert property (@(posedge clk) disable iff (!rstN)
    enRest |-> enFew);

  // R3
  clk_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> (!clampOut && !retainEn));

  // R5
  rst_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    asyncRst |-> (enFew && enRest && clampOut));

  // R2
  off_after_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enFew) |-> (clampOut && retainEn && !clkEn));

  // R6
  release_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clampOut) |-> (retainEn && enRest && !asyncRst && !clkEn));

  // R8
  idle_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enFew && !enRest) |-> coreIdle);

endmodule

// File: rtl/pg_seq_ctrl.sv
module pg_seq_ctrl
  import pg_seq_pkg::*;
#(
  parameter int CHARGE_STEP = 4,
  parameter int RESTORE_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pdTrigger,
  input  logic                 wakeReq,
  input  logic [1:0]           wakeMode,
  input  logic [RESTORE_W-1:0] restoreCycles,
  output logic                 clkEn,
  output logic                 retainEn,
  output logic                 clampOut,
  output logic                 enFew,
  output logic                 enRest,
  output logic                 asyncRst,
  output logic                 coreIdle
);

  pgStrobe_t strobe;
  logic      cntDone;

  pg_seq_fsm i_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .pdTrigger(pdTrigger),
    .wakeReq  (wakeReq),
    .cntDone  (cntDone),
    .strobe   (strobe),
    .clkEn    (clkEn),
    .retainEn (retainEn),
    .clampOut (clampOut),
    .enFew    (enFew),
    .enRest   (enRest),
    .asyncRst (asyncRst),
    .coreIdle (coreIdle)
  );

  pg_seq_timer #(
    .CHARGE_STEP(CHARGE_STEP),
    .RESTORE_W  (RESTORE_W)
  ) i_timer (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wakeMode     (wakeMode),
    .restoreCycles(restoreCycles),
    .cntDone      (cntDone)
  );

endmodule

// File: tb/test_pg_seq_ctrl.sv
`timescale 1ns/1ps
module test_pg_seq_ctrl;

  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pdTrigger = 1'b0;
  logic          wakeReq = 1'b0;
  logic [1:0]    wakeMode = 2'd0;
  logic [RW-1:0] restoreCycles = '0;
  logic clkEn, retainEn, clampOut, enFew, enRest, asyncRst, coreIdle;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  pg_seq_ctrl #(.CHARGE_STEP(4), .RESTORE_W(RW)) i_pg_seq_ctrl (
    .clk(clk), .rstN(rstN), .pdTrigger(pdTrigger), .wakeReq(wakeReq),
    .wakeMode(wakeMode), .restoreCycles(restoreCycles),
    .clkEn(clkEn), .retainEn(retainEn), .clampOut(clampOut),
    .enFew(enFew), .enRest(enRest), .asyncRst(asyncRst), .coreIdle(coreIdle)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // outputs packed {clkEn,retainEn,clampOut,enFew,enRest,asyncRst,coreIdle}
  function automatic int outVec();
    return int'({clkEn, retainEn, clampOut, enFew, enRest, asyncRst, coreIdle});
  endfunction

  task automatic checkRunning(input string req);
    check(req, "running outputs", outVec(), 'b1001100);
  endtask

  // starts on a negedge in running state, ends on the first off-state negedge
  task automatic powerDown(input bit holdWake);
    pdTrigger = 1'b1;
    @(negedge clk);
    pdTrigger = 1'b0;
    check("R2", "step1 clock stopped", outVec(), 'b0001101);
    check("R8", "idle at step1", int'(coreIdle), 1);
    if (holdWake) wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    check("R2", "step2 retention", outVec(), 'b0101101);
    @(negedge clk);
    check("R2", "step3 clamp", outVec(), 'b0111101);
    @(negedge clk);
    check("R2", "step4 switches off", outVec(), 'b0110001);
  endtask

  // starts on the first charge-cycle negedge, runs to clock re-enable
  task automatic finishWake(input int mode, input int rest, input bit poke);
    int few = 0, rst = 0, mid = 0, idle = 0, i = 0;
    int relC = -1, relR = -1;
    int expRest = (rest == 0) ? 1 : rest;
    while (!clkEn && i < 400) begin
      if (poke && i == 1) pdTrigger = 1'b1;
      if (enFew && !enRest) few++;
      if (asyncRst) rst++;
      if (enRest && !asyncRst && clampOut) mid++;
      if (coreIdle) idle++;
      if (relC < 0 && !clampOut) begin
        relC = i;
        check("R8", "idle low at clamp release", int'(coreIdle), 0);
      end
      if (relR < 0 && !retainEn) relR = i;
      @(negedge clk);
      pdTrigger = 1'b0;
      i++;
    end
    check("R4", $sformatf("charge cycles mode %0d", mode), few, 4 * (mode + 1));
    check("R5", "reset pulse cycles", rst, 2);
    check("R6", $sformatf("powered clamped cycles restore %0d", rest), mid, 1 + expRest);
    check("R8", "idle cycles in wake", idle, 4 * (mode + 1) + 3 + expRest);
    check("R6", "retain release after clamp", relR - relC, 1);
    check("R6", "clock after retain", i - relR, 1);
    checkRunning("R6");
  endtask

  task automatic wakeFromOff(input int mode, input int rest, input bit poke);
    wakeMode = 2'(mode);
    restoreCycles = RW'(rest);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    check("R4", "first charge cycle", outVec(), 'b0111001);
    finishWake(mode, rest, poke);
  endtask

  task automatic testReset();
    checkRunning("R1");
  endtask

  task automatic testModes();
    for (int m = 0; m < 4; m++) begin
      powerDown(1'b0);
      repeat (3) @(negedge clk);
      check("R2", "off state held", outVec(), 'b0110001);
      wakeFromOff(m, 3, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic testRestoreEdges();
    powerDown(1'b0);
    wakeFromOff(1, 0, 1'b0);
    @(negedge clk);
    powerDown(1'b0);
    wakeFromOff(2, 9, 1'b0);
    @(negedge clk);
  endtask

  task automatic testHeldWake();
    wakeMode = 2'd0;
    restoreCycles = RW'(2);
    powerDown(1'b1);
    @(negedge clk);
    check("R7", "held wake starts charge", outVec(), 'b0111001);
    finishWake(0, 2, 1'b0);
    @(negedge clk);
  endtask

  task automatic testIgnored();
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    repeat (3) begin
      @(negedge clk);
      checkRunning("R9");
    end
    powerDown(1'b0);
    wakeFromOff(3, 1, 1'b1);
    @(negedge clk);
    checkRunning("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModes();
    testRestoreEdges();
    testHeldWake();
    testIgnored();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule